// File: doc/BRIEF.md
# Linear Photodiode Array Control Sequencer

This block is the digital switch-control logic of a linear photodiode sensor whose pixels are all sampled at once. A single start token, captured from the serial start input at a rising pixel-clock edge, does three things. It freezes every pixel's sampled charge with a one-clock hold pulse. It opens a fixed window in which all integrators are held in reset. It then walks a readout selection across the pixels, one pixel per clock, so that an analog multiplexer can put each stored value on the output in turn.

Integration restarts for every pixel on the clock that follows the reset window. The readout ends on the clock after the last pixel, when the output enable falls; that enable stands in for the high-impedance state of the analog output. Only the timing of the switches is modelled here. The photodiodes, the integrators, the capacitors and the amplifier are outside this block.

The pixel count and the reset-window length are parameters. The pixel count must be larger than the reset window. A start token that arrives while a readout is still running raises a sticky error flag and restarts the sequence from the first pixel.

Top module: `lpa_seq`

## Requirements
- R1: When si is high at a rising clk edge, a cycle starts: after that edge outEn is high, idle is low and pixel 1 is selected.
- R2: holdPulse is high for exactly the one clock period that follows the capture edge, and it is high only while pixel 1 is selected.
- R3: intReset is high after the capture edge and stays high through edge 18 of the cycle, counting the capture edge as edge 1. It falls on edge 19. integrating is always the complement of intReset.
- R4: After edge k of a cycle (1 <= k <= PIXELS), pixIdx equals k and pixSel has only bit k-1 set. Bit 0 stands for pixel 1.
- R5: On edge PIXELS+1 of a cycle, outEn falls, pixIdx returns to 0, pixSel becomes all zero and idle rises.
- R6: Whenever no readout is running, outEn is low and pixSel is all zero. While a readout is running, outEn is high and pixSel is nonzero.
- R7: If si is captured while outEn is high, protoErr is set and stays set until reset. The sequence restarts at pixel 1, with a new hold pulse and a new 18-clock reset window.
- R8: An asynchronous reset (rstN low) clears the selection, protoErr and outEn, raises idle, and sets intReset. intReset stays high, with no si, until the first captured si.
- R9: After a readout ends, intReset stays low until the next si. A start token that arrives after the end reasserts intReset and leaves protoErr unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| si | input | 1 | Serial start; high for one rising edge starts a cycle |
| holdPulse | output | 1 | One-clock pulse that freezes all sampling capacitors |
| intReset | output | 1 | Global integrator reset level |
| integrating | output | 1 | High while the pixels integrate |
| pixSel | output | PIXELS | One-hot readout select; bit 0 is pixel 1 |
| pixIdx | output | $clog2(PIXELS+1) | Selected pixel number, 0 when none is selected |
| outEn | output | 1 | Analog output driven; low means high impedance |
| idle | output | 1 | No readout is running |
| protoErr | output | 1 | Sticky flag: start token seen during a readout |

## Verification
The embedded properties check several things on every cycle:
- the one-hot shape of the select, and its agreement with the index and with outEn;
- that the hold pulse coincides with pixel 1;
- the one-step advance of the index;
- that the reset releases only at pixel 19;
- that the readout stops after the last pixel;
- that the error flag stays set.

Other behaviour needs the bench's scenarios. These cover the absolute edge count of each transition, the cold state held without a start token, a restart in mid-readout, an integration that persists past the readout end, and an asynchronous reset taken in mid-cycle.

// File: rtl/lpa_pkg.sv
package lpa_pkg;

  // Strobes sent from the control FSM to the readout datapath.
  // load has priority over clear, and clear has priority over advance.
  typedef struct packed {
    logic load;     // put the token on pixel 1
    logic advance;  // move the token to the next pixel
    logic clear;    // drop the token out of the chain
  } seqStrobe_t;

endpackage

// File: rtl/lpa_datapath.sv
module lpa_datapath
  import lpa_pkg::*;
#(
  parameter int PIXELS = 128,
  parameter int IDXW   = $clog2(PIXELS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  output logic [PIXELS-1:0] pixSel,
  output logic [IDXW-1:0]   pixIdx,
  output logic              lastPix
);

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(PIXELS);

  // Pixel index counter: 0 means that no pixel is selected.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixIdx <= '0;
    end else if (stb.load) begin
      pixIdx <= IDXW'(1);
    end else if (stb.clear) begin
      pixIdx <= '0;
    end else if (stb.advance) begin
      pixIdx <= pixIdx + IDXW'(1);
    end
  end

  // One-hot token chain that drives the analog multiplexer.
  genvar g;
  generate
    for (g = 0; g < PIXELS; g++) begin : gChain
      logic nextBit;
      if (g == 0) begin : gHead
        always_comb begin
          if (stb.load)                      nextBit = 1'b1;
          else if (stb.clear || stb.advance) nextBit = 1'b0;
          else                               nextBit = pixSel[0];
        end
      end else begin : gBody
        always_comb begin
          if (stb.load || stb.clear) nextBit = 1'b0;
          else if (stb.advance)      nextBit = pixSel[g-1];
          else                       nextBit = pixSel[g];
        end
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pixSel[g] <= 1'b0;
        else       pixSel[g] <= nextBit;
      end
    end
  endgenerate

  assign lastPix = (pixIdx == LAST_IDX);

  // R4
  sel_matches_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixIdx != '0) |-> pixSel[pixIdx - IDXW'(1)]);

  // R4
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixIdx <= LAST_IDX);

endmodule

// File: rtl/lpa_ctrl.sv
module lpa_ctrl
  import lpa_pkg::*;
#(
  parameter int RESET_CLKS = 18,
  parameter int CNTW       = $clog2(RESET_CLKS + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       si,
  input  logic       lastPix,
  output seqStrobe_t stb,
  output logic       scanning,
  output logic       holdPulse,
  output logic       intReset,
  output logic       protoErr
);

  localparam logic [CNTW-1:0] WIN_END = CNTW'(RESET_CLKS);

  // Counts the clock edges of the reset window; 0 means not counting.
  logic [CNTW-1:0] winCnt;

  always_comb begin
    stb.load    = si;
    stb.clear   = !si && scanning && lastPix;
    stb.advance = !si && scanning && !lastPix;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanning <= 1'b0;
    end else if (stb.load) begin
      scanning <= 1'b1;
    end else if (stb.clear) begin
      scanning <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdPulse <= 1'b0;
    else       holdPulse <= si;
  end

  // The reset level starts high after power-up and stays high until a
  // start token opens a counted window.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intReset <= 1'b1;
      winCnt   <= '0;
    end else if (si) begin
      intReset <= 1'b1;
      winCnt   <= CNTW'(1);
    end else if (winCnt == WIN_END) begin
      intReset <= 1'b0;
      winCnt   <= '0;
    end else if (winCnt != '0) begin
      winCnt   <= winCnt + CNTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               protoErr <= 1'b0;
    else if (si && scanning) protoErr <= 1'b1;
  end

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  // R3
  reset_rise_with_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intReset) |-> holdPulse);

  // R2
  hold_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdPulse && !si) |=> !holdPulse);

endmodule

// File: rtl/lpa_seq.sv
module lpa_seq
  import lpa_pkg::*;
#(
  parameter int PIXELS     = 128,
  parameter int RESET_CLKS = 18,
  parameter int IDXW       = $clog2(PIXELS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              si,
  output logic              holdPulse,
  output logic              intReset,
  output logic              integrating,
  output logic [PIXELS-1:0] pixSel,
  output logic [IDXW-1:0]   pixIdx,
  output logic              outEn,
  output logic              idle,
  output logic              protoErr
);

  seqStrobe_t stb;
  logic       lastPix;
  logic       scanning;

  lpa_ctrl #(.RESET_CLKS(RESET_CLKS)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .si       (si),
    .lastPix  (lastPix),
    .stb      (stb),
    .scanning (scanning),
    .holdPulse(holdPulse),
    .intReset (intReset),
    .protoErr (protoErr)
  );

  lpa_datapath #(.PIXELS(PIXELS), .IDXW(IDXW)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .pixSel (pixSel),
    .pixIdx (pixIdx),
    .lastPix(lastPix)
  );

  assign outEn       = scanning;
  assign idle        = !scanning;
  assign integrating = !intReset;

  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pixSel));

  // R6
  oe_matches_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEn == (pixSel != '0));

  // R2
  hold_on_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdPulse |-> (outEn && pixIdx == IDXW'(1)));

  // R4
  advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outEn && !si && pixIdx != IDXW'(PIXELS)) |=>
      (pixIdx == $past(pixIdx) + IDXW'(1)));

  // R3
  release_at_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intReset) |-> (pixIdx == IDXW'(RESET_CLKS + 1)));

  // R5
  end_of_scan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outEn && pixIdx == IDXW'(PIXELS) && !si) |=> (!outEn && idle));

endmodule

// File: tb/test_lpa_seq.sv
module test_lpa_seq;

  localparam int PIXELS = 128;
  localparam int IDXW   = $clog2(PIXELS + 1);
  localparam time CLK_P = 5ns;

  typedef struct packed {
    int edgeNo;
    int idx;
    bit oe;
    bit ir;
    bit hp;
    bit idl;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1,   1,   1'b1, 1'b1, 1'b1, 1'b0},
    '{2,   2,   1'b1, 1'b1, 1'b0, 1'b0},
    '{17,  17,  1'b1, 1'b1, 1'b0, 1'b0},
    '{18,  18,  1'b1, 1'b1, 1'b0, 1'b0},
    '{19,  19,  1'b1, 1'b0, 1'b0, 1'b0},
    '{20,  20,  1'b1, 1'b0, 1'b0, 1'b0},
    '{128, 128, 1'b1, 1'b0, 1'b0, 1'b0},
    '{129, 0,   1'b0, 1'b0, 1'b0, 1'b1},
    '{135, 0,   1'b0, 1'b0, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic si = 1'b0;
  logic holdPulse, intReset, integrating, outEn, idle, protoErr;
  logic [PIXELS-1:0] pixSel;
  logic [IDXW-1:0]   pixIdx;

  int checks = 0;
  int failures = 0;
  int edges = 0;
  bit done = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  lpa_seq #(.PIXELS(PIXELS)) i_lpa_seq (
    .clk(clk), .rstN(rstN), .si(si),
    .holdPulse(holdPulse), .intReset(intReset), .integrating(integrating),
    .pixSel(pixSel), .pixIdx(pixIdx), .outEn(outEn), .idle(idle),
    .protoErr(protoErr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [PIXELS-1:0] selFor(input int idx);
    logic [PIXELS-1:0] v = '0;
    if (idx > 0) v[idx-1] = 1'b1;
    return v;
  endfunction

  // Drive si for one rising edge; afterwards we are at the negedge after edge 1.
  task automatic startCycle();
    @(negedge clk);
    si = 1'b1;
    @(posedge clk);
    @(negedge clk);
    si = 1'b0;
    edges = 1;
  endtask

  task automatic stepTo(input int k);
    while (edges < k) begin
      @(posedge clk);
      @(negedge clk);
      edges++;
    end
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 3);
    // R8: reset state
    chk("R8", "outEn in reset", int'(outEn), 0);
    chk("R8", "pixIdx in reset", int'(pixIdx), 0);
    chk("R8", "intReset in reset", int'(intReset), 1);
    chk("R8", "protoErr in reset", int'(protoErr), 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    // R8, R6: cold state without si
    chk("R8", "intReset held before first si", int'(intReset), 1);
    chk("R6", "outEn idle", int'(outEn), 0);
    chk("R6", "pixSel idle zero", int'(pixSel == '0), 1);
    chk("R8", "idle high", int'(idle), 1);

    // Table walk through one full cycle (R1..R5)
    startCycle();
    for (int i = 0; i < NVEC; i++) begin
      stepTo(VECS[i].edgeNo);
      chk("R4", $sformatf("pixIdx @%0d", edges), int'(pixIdx), VECS[i].idx);
      chk("R4", $sformatf("pixSel @%0d", edges), int'(pixSel == selFor(VECS[i].idx)), 1);
      chk("R1_R5", $sformatf("outEn @%0d", edges), int'(outEn), int'(VECS[i].oe));
      chk("R3", $sformatf("intReset @%0d", edges), int'(intReset), int'(VECS[i].ir));
      chk("R3", $sformatf("integrating @%0d", edges), int'(integrating), int'(!VECS[i].ir));
      chk("R2", $sformatf("holdPulse @%0d", edges), int'(holdPulse), int'(VECS[i].hp));
      chk("R5", $sformatf("idle @%0d", edges), int'(idle), int'(VECS[i].idl));
      chk("R7", $sformatf("protoErr @%0d", edges), int'(protoErr), 0);
    end

    // R9: integration persists past the end until the next si
    stepTo(300);
    chk("R9", "intReset low after end", int'(intReset), 0);
    startCycle();
    chk("R9", "intReset reasserted", int'(intReset), 1);
    chk("R9", "no error on legal restart", int'(protoErr), 0);

    // R7: restart in mid-readout
    stepTo(50);
    chk("R7", "pixIdx before restart", int'(pixIdx), 50);
    startCycle();
    chk("R7", "protoErr set", int'(protoErr), 1);
    chk("R7", "pixIdx restarted", int'(pixIdx), 1);
    chk("R7", "hold on restart", int'(holdPulse), 1);
    chk("R7", "intReset on restart", int'(intReset), 1);
    stepTo(18);
    chk("R7", "window still open @18", int'(intReset), 1);
    stepTo(19);
    chk("R7", "window closes @19", int'(intReset), 0);
    stepTo(129);
    chk("R7", "readout ends after restart", int'(outEn), 0);
    chk("R7", "protoErr sticky", int'(protoErr), 1);

    // R8: asynchronous reset in mid-cycle
    startCycle();
    stepTo(10);
    #1;
    rstN = 1'b0;
    #1;
    chk("R8", "async outEn", int'(outEn), 0);
    chk("R8", "async pixSel", int'(pixSel == '0), 1);
    chk("R8", "async protoErr", int'(protoErr), 0);
    chk("R8", "async intReset", int'(intReset), 1);
    chk("R8", "async idle", int'(idle), 1);
    @(negedge clk);
    rstN = 1'b1;
    repeat (30) @(negedge clk);
    chk("R8", "intReset held after reset", int'(intReset), 1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule